// File: doc/BRIEF.md
# TDM Receive Time-Slot Router

This block receives a serial time-division-multiplexed bit stream. A clock enable marks each bit, and a frame-sync strobe marks the first bit of a frame. The stream is cut into 8-bit slots. Each slot position has an entry in a 64-entry routing table, and a host loads that table through a simple address/data/write-enable port. An entry decides three things: whether the slot is carried at all, which bits of the slot belong to the routed channel, and which channel receives them. An entry can also mark the slot as the last one of the frame.

Each channel has its own bit counter and shift register, so a channel can collect a sub-slot field (for example a nibble per frame) over several frames. When a channel has gathered eight delivered bits, the block emits a one-cycle byte strobe. The strobe carries the packed byte and the channel's 12-bit parameter-area address, which is the 6-bit pointer followed by six zero bits. Pointers with the top bit set fall outside the 2 KB parameter range. Such a pointer raises an error pulse, and the bits of that slot are dropped.

Top module: `tdm_rx_router`

## Requirements
- R1: After reset, `byte_valid` and `ptr_err` are 0, every table entry reads as invalid, and the walk stays idle: bits arriving before the first frame-sync are ignored.
- R2: A host write (`tbl_we`=1 at a clock edge) stores `tbl_wdata` at entry `tbl_addr`. Entry layout: bit 15 valid, bit 14 last-slot, bits 13:8 channel pointer, bits 7:0 bit-select mask.
- R3: A slot whose entry has valid=0 delivers none of its 8 bits to any channel.
- R4: In a valid slot, the k-th bit received (k=0 first, k=7 last) is delivered to the channel named by the pointer when mask bit k is 1.
- R5: When a valid slot's pointer has bit 5 set, `ptr_err` is 1 for one cycle, in the cycle after the edge that samples the slot's first bit, and none of that slot's bits reach any channel.
- R6: A bit whose mask bit is 0 is skipped and does not advance the channel's bit counter.
- R7: After the slot of an entry with the last-slot bit set, or after entry 63, further bits are ignored until the next frame-sync.
- R8: In the cycle after the edge that samples a channel's eighth delivered bit, `byte_valid` is 1 for one cycle, `byte_addr` = {pointer, 6'b0}, and `byte_data` holds the first delivered bit in bit 0 and the last in bit 7.
- R9: A bit sampled with `fsync`=1 is always taken as bit 0 of slot 0, even in the middle of a frame.
- R10: Partial bytes of different channels accumulate independently and persist across frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Qualifies `tdm_bit` as one serial bit in this cycle |
| tdm_bit | input | 1 | Serial receive data |
| fsync | input | 1 | Frame start; sampled together with `bit_en` |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 6 | Table entry index |
| tbl_wdata | input | 16 | Table entry value |
| byte_valid | output | 1 | One-cycle strobe for a completed channel byte |
| byte_addr | output | 12 | Parameter-area address of the channel |
| byte_data | output | 8 | Packed byte |
| ptr_err | output | 1 | Out-of-range pointer on a valid slot |

## Verification
Every result is registered once. `byte_valid` with its address and data, and `ptr_err`, appear in the cycle that follows the rising edge that samples the bit that causes them. A table write applies to bits sampled from the edge after the write onward. The bench drives inputs on falling edges and samples outputs on the next falling edge after the causing bit. Byte strobes are also logged at every falling edge. This lets the bench check that no extra byte was produced while bits were ignored or masked.

// File: rtl/tdm_rt_pkg.sv
package tdm_rt_pkg;
   localparam int SLOT_BITS = 8;
   localparam int BPOS_W    = $clog2(SLOT_BITS);

   typedef logic [BPOS_W-1:0] bpos_t;

   typedef enum logic {
      WALK_IDLE = 1'b0,
      WALK_RUN  = 1'b1
   } walk_st_e;
endpackage

// File: rtl/tdm_slot_table.sv
module tdm_slot_table #(
   parameter int SLOTS = 64,
   parameter int ENT_W = 16,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SLOT_W-1:0] waddr,
   input  logic [ENT_W-1:0]  wdata,
   input  logic [SLOT_W-1:0] raddr,
   output logic [ENT_W-1:0]  rdata
);
   logic [ENT_W-1:0] ent_w [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_ent
      logic [ENT_W-1:0] ent_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_r <= '0;
         else if (we && waddr == SLOT_W'(g))
            ent_r <= wdata;
      end
      assign ent_w[g] = ent_r;
   end

   assign rdata = ent_w[raddr];
endmodule

// File: rtl/tdm_slot_walker.sv
module tdm_slot_walker
   import tdm_rt_pkg::*;
#(
   parameter int SLOTS = 64,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              fsync,
   input  logic              ent_last,
   output logic              cur_active,
   output logic [SLOT_W-1:0] cur_slot,
   output bpos_t             cur_bpos
);
   walk_st_e          st_q;
   logic [SLOT_W-1:0] slot_q;
   bpos_t             bpos_q;
   logic              slot_end;
   logic              frame_end;

   assign cur_active = bit_en && (fsync || st_q == WALK_RUN);
   assign cur_slot   = fsync ? '0 : slot_q;
   assign cur_bpos   = fsync ? '0 : bpos_q;
   assign slot_end   = cur_bpos == bpos_t'(SLOT_BITS - 1);
   assign frame_end  = ent_last || cur_slot == SLOT_W'(SLOTS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= WALK_IDLE;
         slot_q <= '0;
         bpos_q <= '0;
      end else if (cur_active) begin
         if (slot_end) begin
            bpos_q <= '0;
            if (frame_end) begin
               st_q   <= WALK_IDLE;
               slot_q <= '0;
            end else begin
               st_q   <= WALK_RUN;
               slot_q <= cur_slot + SLOT_W'(1);
            end
         end else begin
            st_q   <= WALK_RUN;
            slot_q <= cur_slot;
            bpos_q <= cur_bpos + bpos_t'(1);
         end
      end
   end

   // R7: an idle walk only leaves idle on a frame-sync bit
   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == WALK_IDLE && !(bit_en && fsync)) |=> st_q == WALK_IDLE);

   // R9: a frame-sync bit always lands on slot 0, bit 0
   assert_fsync_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && fsync) |=> (st_q == WALK_RUN && slot_q == '0 && bpos_q == bpos_t'(1)));
endmodule

// File: rtl/tdm_chan_packer.sv
module tdm_chan_packer
   import tdm_rt_pkg::*;
#(
   parameter int  NUM_CH    = 32,
   parameter bit  LSB_FIRST = 1'b1,
   localparam int CH_W      = $clog2(NUM_CH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 del_vld,
   input  logic [CH_W-1:0]      del_ch,
   input  logic                 del_bit,
   output logic                 byte_vld,
   output logic [CH_W-1:0]      byte_ch,
   output logic [SLOT_BITS-1:0] byte_data
);
   logic [SLOT_BITS-1:0] sh_w  [NUM_CH];
   bpos_t                cnt_w [NUM_CH];
   logic [SLOT_BITS-1:0] sh_sel;
   logic [SLOT_BITS-1:0] sh_nxt;
   bpos_t                cnt_sel;

   assign sh_sel  = sh_w[del_ch];
   assign cnt_sel = cnt_w[del_ch];

   if (LSB_FIRST) begin : g_lsb
      assign sh_nxt = {del_bit, sh_sel[SLOT_BITS-1:1]};
   end else begin : g_msb
      assign sh_nxt = {sh_sel[SLOT_BITS-2:0], del_bit};
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic [SLOT_BITS-1:0] sh_r;
      bpos_t                cnt_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_r  <= '0;
            cnt_r <= '0;
         end else if (del_vld && del_ch == CH_W'(g)) begin
            sh_r  <= sh_nxt;
            cnt_r <= cnt_r + bpos_t'(1);
         end
      end
      assign sh_w[g]  = sh_r;
      assign cnt_w[g] = cnt_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_vld  <= 1'b0;
         byte_ch   <= '0;
         byte_data <= '0;
      end else begin
         byte_vld  <= del_vld && cnt_sel == bpos_t'(SLOT_BITS - 1);
         byte_ch   <= del_ch;
         byte_data <= sh_nxt;
      end
   end

   // R8: a byte strobe always follows a delivered bit
   assert_byte_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> $past(del_vld));

   // R8: the strobe lasts one cycle unless another channel byte completes
   assert_byte_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !del_vld) |=> !byte_vld);
endmodule

// File: rtl/tdm_rx_router.sv
module tdm_rx_router
   import tdm_rt_pkg::*;
#(
   parameter int  SLOTS     = 64,
   parameter int  PTR_W     = 6,
   parameter int  ADDR_LO_W = 6,
   parameter bit  LSB_FIRST = 1'b1,
   localparam int SLOT_W    = $clog2(SLOTS),
   localparam int ENT_W     = 2 + PTR_W + SLOT_BITS,
   localparam int ADDR_W    = PTR_W + ADDR_LO_W,
   localparam int CH_W      = PTR_W - 1,
   localparam int NUM_CH    = 2 ** CH_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_en,
   input  logic                 tdm_bit,
   input  logic                 fsync,
   input  logic                 tbl_we,
   input  logic [SLOT_W-1:0]    tbl_addr,
   input  logic [ENT_W-1:0]     tbl_wdata,
   output logic                 byte_valid,
   output logic [ADDR_W-1:0]    byte_addr,
   output logic [SLOT_BITS-1:0] byte_data,
   output logic                 ptr_err
);
   initial begin
      assert (SLOTS >= 2 && SLOTS <= 2 ** SLOT_W)
         else $error("SLOTS out of range");
      assert (PTR_W >= 2)
         else $error("PTR_W must be at least 2");
   end

   logic [ENT_W-1:0]     ent;
   logic                 ent_valid;
   logic                 ent_last;
   logic [PTR_W-1:0]     ent_ptr;
   logic [SLOT_BITS-1:0] ent_mask;
   logic                 ptr_bad;
   logic                 cur_active;
   logic [SLOT_W-1:0]    cur_slot;
   bpos_t                cur_bpos;
   logic                 del_vld;
   logic [CH_W-1:0]      byte_ch;

   tdm_slot_table #(.SLOTS(SLOTS), .ENT_W(ENT_W)) u_table (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tbl_we),
      .waddr (tbl_addr),
      .wdata (tbl_wdata),
      .raddr (cur_slot),
      .rdata (ent)
   );

   assign ent_valid = ent[ENT_W-1];
   assign ent_last  = ent[ENT_W-2];
   assign ent_ptr   = ent[SLOT_BITS +: PTR_W];
   assign ent_mask  = ent[SLOT_BITS-1:0];
   assign ptr_bad   = ent_ptr[PTR_W-1];

   tdm_slot_walker #(.SLOTS(SLOTS)) u_walker (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .fsync      (fsync),
      .ent_last   (ent_last),
      .cur_active (cur_active),
      .cur_slot   (cur_slot),
      .cur_bpos   (cur_bpos)
   );

   assign del_vld = cur_active && ent_valid && !ptr_bad && ent_mask[cur_bpos];

   tdm_chan_packer #(.NUM_CH(NUM_CH), .LSB_FIRST(LSB_FIRST)) u_packer (
      .clk       (clk),
      .rst_n     (rst_n),
      .del_vld   (del_vld),
      .del_ch    (ent_ptr[CH_W-1:0]),
      .del_bit   (tdm_bit),
      .byte_vld  (byte_valid),
      .byte_ch   (byte_ch),
      .byte_data (byte_data)
   );

   assign byte_addr = {1'b0, byte_ch, {ADDR_LO_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_err <= 1'b0;
      else
         ptr_err <= cur_active && ent_valid && ptr_bad && cur_bpos == '0;
   end

   // R5: a rejected slot never completes a byte in the same cycle it is flagged
   assert_err_no_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_err |-> !byte_valid);

   // R5: the error is a single-cycle pulse
   assert_err_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_err |=> !ptr_err);
endmodule

// File: tb/tdm_rx_router_bench.sv
module tdm_rx_router_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0;
   logic        tdm_bit = 1'b0;
   logic        fsync = 1'b0;
   logic        tbl_we = 1'b0;
   logic [5:0]  tbl_addr = '0;
   logic [15:0] tbl_wdata = '0;
   logic        byte_valid;
   logic [11:0] byte_addr;
   logic [7:0]  byte_data;
   logic        ptr_err;

   int checks = 0;
   int errors = 0;
   int nlog = 0;
   int nerr = 0;
   logic [11:0] log_addr [64];
   logic [7:0]  log_data [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   tdm_rx_router u_tdm_rx_router (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tdm_bit(tdm_bit), .fsync(fsync),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
      .byte_valid(byte_valid), .byte_addr(byte_addr), .byte_data(byte_data),
      .ptr_err(ptr_err)
   );

   always @(negedge clk) begin
      if (rst_n && byte_valid && nlog < 64) begin
         log_addr[nlog] = byte_addr;
         log_data[nlog] = byte_data;
         nlog++;
      end
      if (rst_n && ptr_err) nerr++;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic check_log(input int idx, input int addr, input int data, input string req);
      check(log_addr[idx] == 12'(addr), req, int'(log_addr[idx]), addr);
      check(log_data[idx] == 8'(data), req, int'(log_data[idx]), data);
   endtask

   task automatic wr_ent(input int idx, input bit v, input bit last, input int ptr, input int mask);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 6'(idx);
      tbl_wdata = {v, last, 6'(ptr), 8'(mask)};
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic send_bit(input logic b, input logic fs);
      @(negedge clk);
      bit_en = 1'b1; tdm_bit = b; fsync = fs;
   endtask

   task automatic idle();
      @(negedge clk);
      bit_en = 1'b0; fsync = 1'b0;
   endtask

   task automatic send_slot(input logic [7:0] d, input bit fs);
      for (int i = 0; i < 8; i++) send_bit(d[i], fs && i == 0);
   endtask

   task automatic t_reset();
      check(byte_valid == 1'b0, "R1 byte_valid at reset", int'(byte_valid), 0);
      check(ptr_err == 1'b0, "R1 ptr_err at reset", int'(ptr_err), 0);
      wr_ent(0, 1, 1, 1, 8'hFF);
      send_slot(8'h12, 0);
      send_slot(8'h34, 0);
      idle(); idle();
      check(nlog == 0, "R1 bits before first fsync ignored", nlog, 0);
   endtask

   task automatic t_frames();
      int base;
      wr_ent(0, 1, 0, 1, 8'hFF);
      wr_ent(1, 1, 0, 2, 8'h0F);
      wr_ent(2, 0, 0, 4, 8'hFF);
      wr_ent(3, 1, 1, 3, 8'hFF);
      base = nlog;
      send_slot(8'hA5, 1);
      idle();
      check(byte_valid == 1'b1, "R8 strobe one cycle after eighth bit", int'(byte_valid), 1);
      check(byte_addr == 12'h040, "R8 address", int'(byte_addr), 'h040);
      check(byte_data == 8'hA5, "R8 data order", int'(byte_data), 'hA5);
      idle();
      check(byte_valid == 1'b0, "R8 strobe width", int'(byte_valid), 0);
      send_slot(8'hC6, 0);
      send_slot(8'hFF, 0);
      send_slot(8'h3C, 0);
      send_slot(8'hAA, 0);
      idle(); idle();
      check(nlog == base + 2, "R3 R7 invalid and post-last slots drop", nlog, base + 2);
      check_log(base + 1, 'h0C0, 'h3C, "R2 R4 last-slot entry routing");
      send_slot(8'h5A, 1);
      send_slot(8'h39, 0);
      send_slot(8'h00, 0);
      send_slot(8'h11, 0);
      idle(); idle();
      check(nlog == base + 5, "R10 byte count over two frames", nlog, base + 5);
      check_log(base + 2, 'h040, 'h5A, "R4 second frame slot 0");
      check_log(base + 3, 'h080, 'h96, "R6 R10 nibble channel across frames");
      check_log(base + 4, 'h0C0, 'h11, "R4 slot 3");
   endtask

   task automatic t_sparse_mask();
      int base;
      wr_ent(0, 1, 1, 6, 8'h55);
      base = nlog;
      send_slot(8'h0F, 1);
      idle();
      check(nlog == base, "R6 partial byte held", nlog, base);
      send_slot(8'hF0, 1);
      idle(); idle();
      check(nlog == base + 1, "R6 masked bits do not count", nlog, base + 1);
      check_log(base, 'h180, 'hC3, "R4 R6 sparse mask packing");
   endtask

   task automatic t_ptr_err();
      int base, eb;
      wr_ent(0, 1, 1, 'h21, 8'hFF);
      base = nlog; eb = nerr;
      send_bit(1'b1, 1'b1);
      idle();
      check(ptr_err == 1'b1, "R5 error after first bit", int'(ptr_err), 1);
      idle();
      check(ptr_err == 1'b0, "R5 error pulse width", int'(ptr_err), 0);
      for (int i = 1; i < 8; i++) send_bit(1'b1, 1'b0);
      send_slot(8'hFF, 1);
      idle(); idle();
      check(nerr == eb + 2, "R5 one error per slot", nerr, eb + 2);
      check(nlog == base, "R5 bits dropped", nlog, base);
      wr_ent(0, 1, 1, 1, 8'hFF);
      send_slot(8'h6B, 1);
      idle(); idle();
      check(nlog == base + 1, "R5 alias channel untouched", nlog, base + 1);
      check_log(base, 'h040, 'h6B, "R5 alias channel byte clean");
   endtask

   task automatic t_resync();
      int base;
      wr_ent(0, 1, 0, 5, 8'hFF);
      wr_ent(1, 0, 1, 0, 8'hFF);
      base = nlog;
      send_bit(1'b1, 1'b1);
      send_bit(1'b0, 1'b0);
      send_bit(1'b1, 1'b0);
      send_slot(8'hF0, 1);
      send_slot(8'hFF, 0);
      idle(); idle();
      check(nlog == base + 1, "R9 restart byte count", nlog, base + 1);
      check_log(base, 'h140, 'h85, "R9 fsync mid-slot restarts at slot 0");
   endtask

   task automatic t_table_end();
      int base;
      for (int i = 0; i < 4; i++) wr_ent(i, 0, 0, 0, 0);
      wr_ent(63, 1, 0, 7, 8'hFF);
      base = nlog;
      for (int s = 0; s < 63; s++) send_slot(8'hFF, s == 0);
      send_slot(8'h77, 0);
      send_slot(8'hFF, 0);
      idle(); idle();
      check(nlog == base + 1, "R7 walk stops after entry 63", nlog, base + 1);
      check_log(base, 'h1C0, 'h77, "R7 entry 63 delivered");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_frames();
      t_sparse_mask();
      t_ptr_err();
      t_resync();
      t_table_end();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule